// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit row vectors by a fixed square matrix of signed 8-bit weights. The result rows are 32-bit signed. The multiply-accumulate cells form an N x N grid. Each cell keeps one weight for as long as that weight matrix is in use. Activations move one cell to the right on each clock, and partial sums move one cell down. A finished product row leaves at the bottom edge of the grid.

Loading and computing are two separate phases. To load, the host holds the load strobe high for N cycles and presents one weight row vector per cycle. The vectors shift down through the grid, so the first vector presented ends in the bottom row. To compute, the host streams A rows on the input port, one per cycle when it has data, with gaps allowed between rows. A skew stage delays each input element so that it meets the right partial sum in the grid. A deskew stage then realigns the column results so that each output row is presented in a single cycle.

Top module: `sysmm_top`

## Requirements
- R1: For every accepted input row a, the output row c satisfies c[j] = sum over k of a[k]*B[k][j], computed in 32-bit two's complement with wraparound. Element k of a vector is carried in bits [k*8 +: 8] of an operand port and in bits [j*32 +: 32] of the result port.
- R2: While `w_load` is high, each cycle shifts the whole weight grid down by one row and writes `w_row` into row 0. After N consecutive load cycles, the vector presented first sits in row k = N-1 and the vector presented last sits in row 0.
- R3: While `w_load` is low, the stored weights do not change. Every input row streamed after a load uses those same weights.
- R4: A row accepted on a clock edge makes `c_valid` high exactly 2N-1 cycles later. All N result elements of that row are on `c_row` in that same cycle.
- R5: Rows can be accepted on consecutive cycles, one per cycle. M accepted rows produce M result rows, in the same order.
- R6: A cycle where `a_valid` is low adds no result. `c_valid` is high only for accepted rows, even when there are gaps between them.
- R7: `a_valid` is ignored while `w_load` is high. Such a cycle produces no result row.
- R8: Operands use the full signed range. For example, -128 * -128 contributes +16384, and four such terms give 65536.
- R9: A synchronous active-high reset clears the following:
  - the activation registers, the partial sums and the valid pipeline, so that `c_valid` and `c_row` read 0;
  - the stored weights, so that a row streamed before any load gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| w_load | input | 1 | Weight shift strobe |
| w_row | input | N*AW | Weight row vector shifted into grid row 0 |
| a_valid | input | 1 | Input row present |
| a_row | input | N*AW | Input row vector, element k in lane k |
| c_valid | output | 1 | Result row present |
| c_row | output | N*SW | Result row vector, element j in lane j |

## Verification
The assertions assume that the weights are not reloaded while rows are still in flight. A change of weights in the middle of a row's trip through the grid would give a result that matches no single weight matrix. The assertions also assume that reset is applied from time zero. The stimulus keeps to both conditions: it idles for more than the pipeline latency before every load, and it raises reset before the first clock edge. It also deliberately drives `a_valid` high during one load, to show that the row is discarded rather than counted.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

   // Cycles from an accepted row to its result: the skew depth, the grid depth and the deskew depth
   function automatic int unsigned sysmm_latency(input int unsigned n);
      return 2 * n - 1;
   endfunction

   // Width needed to hold a sum of n products of aw-bit operands without overflow
   function automatic int unsigned sysmm_min_acc(input int unsigned aw, input int unsigned n);
      return 2 * aw + $clog2(n) + 1;
   endfunction

endpackage

// File: rtl/sysmm_skew.sv
// Per-lane delay line. REVERSE = 0 delays lane k by k cycles; REVERSE = 1 delays lane k by N-1-k cycles.
module sysmm_skew #(
   parameter int unsigned N       = 4,
   parameter int unsigned W       = 8,
   parameter bit          REVERSE = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N*W-1:0] d,
   output logic [N*W-1:0] q
);

   for (genvar k = 0; k < N; k++) begin : g_lane
      localparam int unsigned DEPTH = REVERSE ? (N - 1 - k) : k;
      if (DEPTH == 0) begin : g_pass
         assign q[k*W +: W] = d[k*W +: W];
      end else begin : g_dly
         logic [W-1:0] stage [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
            end else begin
               stage[0] <= d[k*W +: W];
               for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
            end
         end
         assign q[k*W +: W] = stage[DEPTH-1];
      end
   end

endmodule

// File: rtl/sysmm_pe.sv
// One multiply-accumulate cell: holds a weight, forwards the activation right and the sum down.
module sysmm_pe #(
   parameter int unsigned AW = 8,
   parameter int unsigned SW = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ld,
   input  logic signed [AW-1:0] a_in,
   input  logic signed [AW-1:0] w_in,
   input  logic signed [SW-1:0] p_in,
   output logic signed [AW-1:0] a_out,
   output logic signed [AW-1:0] w_out,
   output logic signed [SW-1:0] p_out
);

   localparam int unsigned PW = 2 * AW;

   logic signed [AW-1:0] a_q;
   logic signed [AW-1:0] w_q;
   logic signed [SW-1:0] p_q;
   logic signed [PW-1:0] prod;

   assign prod = a_in * w_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         w_q <= '0;
         p_q <= '0;
      end else begin
         a_q <= a_in;
         p_q <= p_in + SW'(prod);
         if (ld) w_q <= w_in;
      end
   end

   assign a_out = a_q;
   assign w_out = w_q;
   assign p_out = p_q;

   // R3: a held weight only changes on a load cycle
   a_r3_weight_frozen: assert property (@(posedge clk) disable iff (rst)
      !ld |=> $stable(w_q));

   // R8: one cell adds at most one full-range product to the incoming sum
   a_r8_step_bound: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((p_q - $past(p_in)) <= SW'(1 << (PW - 2)) &&
                       (p_q - $past(p_in)) >= -SW'(1 << (PW - 2))));

endmodule

// File: rtl/sysmm_grid.sv
// N x N cell array: activations move right, partial sums and loaded weights move down.
module sysmm_grid #(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 8,
   parameter int unsigned SW = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld,
   input  logic [N*AW-1:0] w_top,
   input  logic [N*AW-1:0] a_left,
   output logic [N*SW-1:0] p_bottom
);

   logic signed [AW-1:0] a_h [N][N+1];
   logic signed [AW-1:0] w_v [N+1][N];
   logic signed [SW-1:0] p_v [N+1][N];

   for (genvar k = 0; k < N; k++) begin : g_edge_l
      assign a_h[k][0] = a_left[k*AW +: AW];
   end

   for (genvar j = 0; j < N; j++) begin : g_edge_t
      assign w_v[0][j]           = w_top[j*AW +: AW];
      assign p_v[0][j]           = '0;
      assign p_bottom[j*SW +: SW] = p_v[N][j];
   end

   for (genvar k = 0; k < N; k++) begin : g_row
      for (genvar j = 0; j < N; j++) begin : g_col
         sysmm_pe #(.AW(AW), .SW(SW)) u_pe (
            .clk   (clk),
            .rst   (rst),
            .ld    (ld),
            .a_in  (a_h[k][j]),
            .w_in  (w_v[k][j]),
            .p_in  (p_v[k][j]),
            .a_out (a_h[k][j+1]),
            .w_out (w_v[k+1][j]),
            .p_out (p_v[k+1][j])
         );
      end
   end

   // Activations leaving the right edge and weights below the bottom row go nowhere
   logic [N*(2*AW)-1:0] unused_edges;
   for (genvar k = 0; k < N; k++) begin : g_unused
      assign unused_edges[k*2*AW +: 2*AW] = {a_h[k][N], w_v[N][k]};
   end
   logic unused_sink;
   assign unused_sink = ^unused_edges;

endmodule

// File: rtl/sysmm_top.sv
module sysmm_top
   import sysmm_pkg::*;
#(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 8,
   parameter int unsigned SW = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            w_load,
   input  logic [N*AW-1:0] w_row,
   input  logic            a_valid,
   input  logic [N*AW-1:0] a_row,
   output logic            c_valid,
   output logic [N*SW-1:0] c_row
);

   localparam int unsigned LAT = sysmm_latency(N);
   localparam int unsigned OW  = $clog2(LAT + 1) + 1;

   if (N < 2) begin : g_chk_n
      $error("sysmm_top: N must be at least 2");
   end
   if (AW < 2) begin : g_chk_aw
      $error("sysmm_top: AW must be at least 2");
   end
   if (SW < sysmm_min_acc(AW, N)) begin : g_chk_sw
      $error("sysmm_top: SW too narrow for N full-range products");
   end

   logic            accept;
   logic [N*AW-1:0] a_gated;
   logic [N*AW-1:0] a_skewed;
   logic [N*SW-1:0] p_ragged;
   logic [LAT-1:0]  vpipe;

   assign accept  = a_valid & ~w_load;
   assign a_gated = accept ? a_row : '0;

   sysmm_skew #(.N(N), .W(AW), .REVERSE(1'b0)) u_skew_in (
      .clk (clk),
      .rst (rst),
      .d   (a_gated),
      .q   (a_skewed)
   );

   sysmm_grid #(.N(N), .AW(AW), .SW(SW)) u_grid (
      .clk      (clk),
      .rst      (rst),
      .ld       (w_load),
      .w_top    (w_row),
      .a_left   (a_skewed),
      .p_bottom (p_ragged)
   );

   sysmm_skew #(.N(N), .W(SW), .REVERSE(1'b1)) u_skew_out (
      .clk (clk),
      .rst (rst),
      .d   (p_ragged),
      .q   (c_row)
   );

   always_ff @(posedge clk) begin
      if (rst) vpipe <= '0;
      else     vpipe <= {vpipe[LAT-2:0], accept};
   end

   assign c_valid = vpipe[LAT-1];

   // Rows accepted but not yet delivered
   logic [OW-1:0] outstanding;
   always_ff @(posedge clk) begin
      if (rst) outstanding <= '0;
      else     outstanding <= outstanding + OW'(accept) - OW'(c_valid);
   end

   // R4: never more rows in flight than the pipeline depth
   a_r4_outstanding_bound: assert property (@(posedge clk) disable iff (rst)
      outstanding <= OW'(LAT));

   // R6: a result is only presented for a previously accepted row
   a_r6_no_orphan_valid: assert property (@(posedge clk) disable iff (rst)
      c_valid |-> (outstanding != '0));

   // R7: a load cycle never adds a row to the pipeline
   a_r7_load_blocks: assert property (@(posedge clk) disable iff (rst)
      w_load |=> (outstanding <= $past(outstanding)));

endmodule

// File: tb/tb_sysmm_top.sv
module tb_sysmm_top;

   localparam int N          = 4;
   localparam int AW         = 8;
   localparam int SW         = 32;
   localparam int LAT        = 2 * N - 1;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            w_load = 1'b0;
   logic [N*AW-1:0] w_row = '0;
   logic            a_valid = 1'b0;
   logic [N*AW-1:0] a_row = '0;
   logic            c_valid;
   logic [N*SW-1:0] c_row;

   sysmm_top #(.N(N), .AW(AW), .SW(SW)) dut (
      .clk     (clk),
      .rst     (rst),
      .w_load  (w_load),
      .w_row   (w_row),
      .a_valid (a_valid),
      .a_row   (a_row),
      .c_valid (c_valid),
      .c_row   (c_row)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int b_mat [N][N];
   int a_vec [N];

   logic [N*SW-1:0] exp_q [$];
   int              cyc_q [$];
   string           tag_q [$];

   // Monitor: pop and compare each result row as it appears
   always @(negedge clk) begin
      if (!rst && c_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R6/R7: unexpected result row at cycle %0d, actual %h expected none", cyc, c_row);
         end else begin
            logic [N*SW-1:0] e;
            int              ec;
            string           t;
            e  = exp_q.pop_front();
            ec = cyc_q.pop_front();
            t  = tag_q.pop_front();
            if (c_row !== e) begin
               fails++;
               $display("FAIL %s: result row actual %h expected %h", t, c_row, e);
            end else if (cyc != ec) begin
               fails++;
               $display("FAIL R4: result cycle actual %0d expected %0d", cyc, ec);
            end
         end
      end
   end

   task automatic check(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s", msg);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         a_valid = 1'b0;
         w_load  = 1'b0;
      end
   endtask

   // R2: present B rows from the last to the first, so row k lands in grid row k
   task automatic load_b(input bit junk);
      for (int s = 0; s < N; s++) begin
         @(posedge clk); #1;
         w_load  = 1'b1;
         a_valid = junk;
         for (int j = 0; j < N; j++) begin
            w_row[j*AW +: AW] = AW'(b_mat[N-1-s][j]);
            a_row[j*AW +: AW] = AW'(j * 17 - 60);
         end
      end
      @(posedge clk); #1;
      w_load  = 1'b0;
      a_valid = 1'b0;
   endtask

   // Driver: present a_vec for one cycle and push its expected product
   task automatic push_row(input string tag);
      logic [N*SW-1:0] e;
      @(posedge clk); #1;
      a_valid = 1'b1;
      for (int k = 0; k < N; k++) a_row[k*AW +: AW] = AW'(a_vec[k]);
      for (int j = 0; j < N; j++) begin
         int acc = 0;
         for (int k = 0; k < N; k++) acc += a_vec[k] * b_mat[k][j];
         e[j*SW +: SW] = SW'(acc);
      end
      exp_q.push_back(e);
      cyc_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
   endtask

   function automatic int rnd8();
      return int'($urandom_range(255)) - 128;
   endfunction

   initial begin
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = 0;

      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R9: outputs cleared by reset
      check(c_valid == 1'b0 && c_row == '0,
            $sformatf("R9: reset state actual valid=%0b row=%h expected 0/0", c_valid, c_row));

      // R9: weights cleared, so a row before any load gives zero
      for (int k = 0; k < N; k++) a_vec[k] = 100 - 37 * k;
      push_row("R9");
      idle(LAT + 2);

      // R2: distinct weights, unit input rows select single B rows
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = k * N + j + 1;
      load_b(1'b0);
      for (int r = 0; r < N; r++) begin
         for (int k = 0; k < N; k++) a_vec[k] = (k == r) ? 1 : 0;
         push_row("R2");
      end
      idle(LAT + 2);

      // R1/R5: random weights, back-to-back random rows
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = rnd8();
      load_b(1'b0);
      for (int r = 0; r < 12; r++) begin
         for (int k = 0; k < N; k++) a_vec[k] = rnd8();
         push_row("R5");
      end
      // R6: rows separated by random gaps
      for (int r = 0; r < 10; r++) begin
         for (int k = 0; k < N; k++) a_vec[k] = rnd8();
         push_row("R6");
         idle(int'($urandom_range(3)));
      end
      idle(LAT + 2);

      // R7: a_valid held high during the load must not create rows; R3: weights reused
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = rnd8();
      load_b(1'b1);
      for (int r = 0; r < 8; r++) begin
         for (int k = 0; k < N; k++) a_vec[k] = rnd8();
         push_row("R3");
      end
      idle(LAT + 2);

      // R8: most negative operands everywhere, then mixed extremes
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = -128;
      load_b(1'b0);
      for (int k = 0; k < N; k++) a_vec[k] = -128;
      push_row("R8");
      for (int k = 0; k < N; k++) a_vec[k] = 127;
      push_row("R8");
      for (int k = 0; k < N; k++) a_vec[k] = (k % 2 == 0) ? -128 : 127;
      push_row("R8");
      idle(LAT + 2);
      for (int k = 0; k < N; k++)
         for (int j = 0; j < N; j++) b_mat[k][j] = ((k + j) % 2 == 0) ? 127 : -128;
      load_b(1'b0);
      for (int k = 0; k < N; k++) a_vec[k] = -128;
      push_row("R1");
      idle(LAT + 2);

      // R5: every pushed row was delivered
      check(exp_q.size() == 0,
            $sformatf("R5: rows left undelivered actual %0d expected 0", exp_q.size()));

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule